// File: doc/BRIEF.md
# Cross-Clock Dual-Port Mailbox Interrupts

This block provides the message-passing corner of a two-port memory whose ports run on unrelated clocks. Two addresses at the very top of the address space are set aside as message words, one owned by each port. A port posts a message by writing the word owned by its peer. The peer's active-low interrupt then asserts. The owner takes the message by reading its own word, and that read withdraws the interrupt.

Each direction has a sender stage in the writer's clock domain. The sender latches the posted word and flips an event toggle. In the owner's domain, a synchronizer chain picks up the toggle. An edge detector then copies the word into an owner-side register and sets the interrupt flag. Because only the toggle and a word that is already stable cross the boundary, no set request is lost, provided the pacing rule in R9 is met. A single asynchronous active-low reset initialises both domains. Reads have one cycle of latency.

Top module: `dpmbox_top`

## Requirements
- R1: While `rst_n` is low and after its release, both `a_irq_n` and `b_irq_n` are 1, both read-data buses are 0, and both mailbox words read back as 0.
- R2: With address width AW, the word owned by port A sits at address 2^AW-1 (all ones), and the word owned by port B sits at address 2^AW-2.
- R3: A write by port B (`b_en`=1, `b_wr`=1) to address 2^AW-1 drives `a_irq_n` to 0 within three rising edges of `a_clk`, counted after the `b_clk` edge that takes the write.
- R4: A write by port A to address 2^AW-2 drives `b_irq_n` to 0 within three rising edges of `b_clk`, counted after the `a_clk` edge that takes the write.
- R5: A read by a port of its own mailbox address (`en`=1, `wr`=0) returns the most recently posted word on that port's read-data bus after the same clock edge. At that edge the port's interrupt returns to 1.
- R6: A port that writes its own mailbox address changes neither interrupt, and the stored word does not change.
- R7: Writes to addresses other than the peer's mailbox have no effect. A read of any address other than the port's own mailbox returns 0.
- R8: If a posted word arrives in the owner's clock domain in the same cycle as an owner read of that mailbox, the interrupt stays asserted (set wins over clear).
- R9: Posts in the same direction that are spaced at least four owner clock cycles apart each raise the interrupt again. Each of them delivers its own word to the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| a_irq_n | output | 1 | Active-low interrupt to port A (message waiting) |
| b_irq_n | output | 1 | Active-low interrupt to port B (message waiting) |

## Verification
The assertions assume that a sender does not post again in the same direction before the owner domain has registered the previous toggle, which is the pacing stated in R9. If it did, two toggle flips could cancel, and the copied word could be sampled while it is changing. The stimulus waits at least six owner clocks after every post before it acts again. Each port's inputs change only on the falling edge of its own clock. The two clocks have unrelated periods, so the phase between the domains drifts across the address sweep. The set-wins case is reached by holding a continuous owner read while a post is in flight.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DEF_AW    = 4;
    localparam int DEF_DW    = 8;
    localparam int DEF_SYNC  = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_sender.sv
module mbox_sender #(
    parameter int              AW        = 4,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   PEER_ADDR = '1,
    parameter logic [AW-1:0]   OWN_ADDR  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          tog,
    output logic [DW-1:0] word
);
    typedef struct packed {
        logic          tog;
        logic [DW-1:0] word;
    } snd_t;

    snd_t s_d, s_q;
    logic post;

    always_comb begin
        s_d  = s_q;
        post = en && wr && (addr == PEER_ADDR);
        if (post) begin
            s_d.tog  = ~s_q.tog;
            s_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tog  = s_q.tog;
    assign word = s_q.word;

    // R3 R4
    post_flips_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && addr == PEER_ADDR) |=> (tog != $past(tog)));

    // R6
    own_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && addr == OWN_ADDR) |=> ($stable(tog) && $stable(word)));
endmodule

// File: rtl/mbox_receiver.sv
module mbox_receiver #(
    parameter int            AW       = 4,
    parameter int            DW       = 8,
    parameter int            SYNC     = 2,
    parameter logic [AW-1:0] OWN_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tog_in,
    input  logic [DW-1:0] word_in,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    output logic          irq_n
);
    typedef struct packed {
        logic          flag;
        logic          seen;
        logic [DW-1:0] word;
        logic [DW-1:0] rdata;
    } rcv_t;

    rcv_t r_d, r_q;
    logic tog_sync;
    logic arrive;
    logic own_rd;

    mbox_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tog_in),
        .dout  (tog_sync)
    );

    always_comb begin
        r_d    = r_q;
        arrive = tog_sync ^ r_q.seen;
        own_rd = en && !wr && (addr == OWN_ADDR);
        r_d.seen = tog_sync;
        if (arrive) r_d.word = word_in;
        if (en && !wr) begin
            if (own_rd) r_d.rdata = arrive ? word_in : r_q.word;
            else        r_d.rdata = '0;
        end
        r_d.flag = arrive || (r_q.flag && !own_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign irq_n = ~r_q.flag;

    // R3 R4 R8
    arrival_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_sync != r_q.seen) |=> !irq_n);

    // R5
    owner_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr && addr == OWN_ADDR && tog_sync == r_q.seen) |=> irq_n);

    // R6 R7
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(tog_sync != r_q.seen));

    // R7
    foreign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr && addr != OWN_ADDR) |=> (rdata == '0));
endmodule

// File: rtl/dpmbox_top.sv
module dpmbox_top
    import mbox_pkg::*;
#(
    parameter int AW   = DEF_AW,
    parameter int DW   = DEF_DW,
    parameter int SYNC = DEF_SYNC
) (
    input  logic          rst_n,
    input  logic          a_clk,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_clk,
    input  logic          b_en,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          a_irq_n,
    output logic          b_irq_n
);
    localparam logic [AW-1:0] BOX_A = '1;
    localparam logic [AW-1:0] BOX_B = BOX_A - 1'b1;

    logic          tog_to_a, tog_to_b;
    logic [DW-1:0] word_to_a, word_to_b;

    mbox_sender #(.AW(AW), .DW(DW), .PEER_ADDR(BOX_A), .OWN_ADDR(BOX_B)) u_snd_b (
        .clk (b_clk), .rst_n (rst_n), .en (b_en), .wr (b_wr),
        .addr (b_addr), .wdata (b_wdata), .tog (tog_to_a), .word (word_to_a)
    );

    mbox_sender #(.AW(AW), .DW(DW), .PEER_ADDR(BOX_B), .OWN_ADDR(BOX_A)) u_snd_a (
        .clk (a_clk), .rst_n (rst_n), .en (a_en), .wr (a_wr),
        .addr (a_addr), .wdata (a_wdata), .tog (tog_to_b), .word (word_to_b)
    );

    mbox_receiver #(.AW(AW), .DW(DW), .SYNC(SYNC), .OWN_ADDR(BOX_A)) u_rcv_a (
        .clk (a_clk), .rst_n (rst_n), .tog_in (tog_to_a), .word_in (word_to_a),
        .en (a_en), .wr (a_wr), .addr (a_addr), .rdata (a_rdata), .irq_n (a_irq_n)
    );

    mbox_receiver #(.AW(AW), .DW(DW), .SYNC(SYNC), .OWN_ADDR(BOX_B)) u_rcv_b (
        .clk (b_clk), .rst_n (rst_n), .tog_in (tog_to_b), .word_in (word_to_b),
        .en (b_en), .wr (b_wr), .addr (b_addr), .rdata (b_rdata), .irq_n (b_irq_n)
    );
endmodule

// File: tb/dpmbox_top_test.sv
module dpmbox_top_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int TOP = (1 << AW) - 1;

    logic          rst_n = 1'b0;
    logic          a_clk = 1'b0, b_clk = 1'b0;
    logic          a_en = 0, a_wr = 0, b_en = 0, b_wr = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_irq_n, b_irq_n;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    int exp_a   = 0;
    int exp_b   = 0;

    always #10 a_clk = ~a_clk;
    always #17 b_clk = ~b_clk;

    dpmbox_top #(.AW(AW), .DW(DW), .SYNC(2)) uut (
        .rst_n (rst_n),
        .a_clk (a_clk), .a_en (a_en), .a_wr (a_wr), .a_addr (a_addr),
        .a_wdata (a_wdata), .a_rdata (a_rdata),
        .b_clk (b_clk), .b_en (b_en), .b_wr (b_wr), .b_addr (b_addr),
        .b_wdata (b_wdata), .b_rdata (b_rdata),
        .a_irq_n (a_irq_n), .b_irq_n (b_irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic a_write(input int adr, input int dat);
        @(negedge a_clk);
        a_en = 1; a_wr = 1; a_addr = adr[AW-1:0]; a_wdata = dat[DW-1:0];
        @(negedge a_clk);
        a_en = 0; a_wr = 0;
    endtask

    task automatic b_write(input int adr, input int dat);
        @(negedge b_clk);
        b_en = 1; b_wr = 1; b_addr = adr[AW-1:0]; b_wdata = dat[DW-1:0];
        @(negedge b_clk);
        b_en = 0; b_wr = 0;
    endtask

    task automatic a_read(input int adr, output int dat);
        @(negedge a_clk);
        a_en = 1; a_wr = 0; a_addr = adr[AW-1:0];
        @(negedge a_clk);
        a_en = 0;
        dat = int'(a_rdata);
    endtask

    task automatic b_read(input int adr, output int dat);
        @(negedge b_clk);
        b_en = 1; b_wr = 0; b_addr = adr[AW-1:0];
        @(negedge b_clk);
        b_en = 0;
        dat = int'(b_rdata);
    endtask

    task automatic settle();
        repeat (6) @(negedge a_clk);
        repeat (6) @(negedge b_clk);
        @(negedge a_clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int rd;
        bit saw_low;
        int last;
        #5;
        check("R1 reset a_irq_n", int'(a_irq_n), 1);
        check("R1 reset b_irq_n", int'(b_irq_n), 1);
        repeat (3) @(negedge a_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge b_clk);
        check("R1 a_rdata after reset", int'(a_rdata), 0);
        check("R1 b_rdata after reset", int'(b_rdata), 0);
        a_read(TOP, rd);     check("R1 A box zero", rd, 0);
        b_read(TOP - 1, rd); check("R1 B box zero", rd, 0);

        // Sweep: port B writes every address (R2 R3 R6 R7)
        for (int adr = 0; adr <= TOP; adr++) begin
            int dat = (adr * 37 + 5) & 8'hFF;
            b_write(adr, dat);
            settle();
            if (adr == TOP) exp_a = dat;
            check($sformatf("R3 a_irq_n after B write @%0d", adr), int'(a_irq_n), (adr == TOP) ? 0 : 1);
            check($sformatf("R6 b_irq_n after B write @%0d", adr), int'(b_irq_n), 1);
            a_read(TOP, rd);
            check($sformatf("R5 A box read after @%0d", adr), rd, exp_a);
            check("R5 a_irq_n cleared", int'(a_irq_n), 1);
            a_read(adr == TOP ? 0 : adr, rd);
            check($sformatf("R7 A foreign read @%0d", adr), rd, 0);
        end

        // Sweep: port A writes every address (R2 R4 R6 R7)
        for (int adr = 0; adr <= TOP; adr++) begin
            int dat = (adr * 53 + 11) & 8'hFF;
            a_write(adr, dat);
            settle();
            if (adr == TOP - 1) exp_b = dat;
            check($sformatf("R4 b_irq_n after A write @%0d", adr), int'(b_irq_n), (adr == TOP - 1) ? 0 : 1);
            check($sformatf("R6 a_irq_n after A write @%0d", adr), int'(a_irq_n), 1);
            b_read(TOP - 1, rd);
            check($sformatf("R5 B box read after @%0d", adr), rd, exp_b);
            check("R5 b_irq_n cleared", int'(b_irq_n), 1);
            b_read(adr == TOP - 1 ? 0 : adr, rd);
            check($sformatf("R7 B foreign read @%0d", adr), rd, 0);
        end
        a_read(TOP, rd);
        check("R6 A box unchanged by own write", rd, exp_a);

        // Repeated posts each raise the flag (R9)
        for (int i = 0; i < 6; i++) begin
            int dat = (i * 71 + 3) & 8'hFF;
            b_write(TOP, dat);
            settle();
            check($sformatf("R9 a_irq_n repost %0d", i), int'(a_irq_n), 0);
            a_read(TOP, rd);
            check($sformatf("R9 A word repost %0d", i), rd, dat);
            a_write(TOP - 1, dat ^ 8'h5A);
            settle();
            check($sformatf("R9 b_irq_n repost %0d", i), int'(b_irq_n), 0);
            b_read(TOP - 1, rd);
            check($sformatf("R9 B word repost %0d", i), rd, dat ^ 8'h5A);
        end

        // Set wins over a simultaneous owner read (R8)
        for (int ph = 0; ph < 4; ph++) begin
            int dat = 8'hC0 + ph;
            repeat (ph) @(negedge b_clk);
            @(negedge a_clk);
            a_en = 1; a_wr = 0; a_addr = TOP[AW-1:0];
            saw_low = 0;
            fork
                b_write(TOP, dat);
                begin
                    repeat (14) begin
                        @(negedge a_clk);
                        if (!a_irq_n) saw_low = 1;
                        last = int'(a_rdata);
                    end
                end
            join
            @(negedge a_clk);
            if (!a_irq_n) saw_low = 1;
            a_en = 0;
            @(negedge a_clk);
            check($sformatf("R8 flag seen under constant read ph%0d", ph), int'(saw_low), 1);
            check($sformatf("R8 flag cleared afterwards ph%0d", ph), int'(a_irq_n), 1);
            check($sformatf("R8 word delivered ph%0d", ph), last, dat);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule